// File: doc/BRIEF.md
# UART Control Register and Channel-Mode Router

This block holds the control word of a serial port and the two-bit channel-mode setting. It steers bytes between three endpoints: the host data port, the transmit side and the receive side. A host write to the data register, or a byte arriving from the line, is routed to a transmit strobe or a receive-queue push strobe. The routing depends on the channel mode in effect and on whether each path is switched on. The block does not serialise bytes, store them or raise interrupts. Neighbouring blocks do that, using the strobes and pulses produced here.

The channel mode is a four-state machine. Its states are `CH_NORMAL`, `CH_ECHO`, `CH_LOCAL` and `CH_REMOTE`. A mode write takes it from any state to the state written, and it stays in that state until the next mode write. Reset places it in `CH_NORMAL`.

The control word has several kinds of bit. Two bits are self-clearing: each one fires a single-cycle flush pulse toward one side, then reads back as zero. The enable and disable bits are set in pairs, and in each pair the disable bit wins. The start-break and stop-break bits together form a break request. Every output is registered. Each one follows the input that caused it by one clock, and it is decided by the control word and mode that were held before that edge.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset, `ctrl_q` reads 0x128, which is receive disable (bit3), transmit disable (bit5) and stop break (bit8) set. `mode_q` reads 0 and every strobe and pulse is low.
- R2: A control write stores bits 2 to 8 as written and reads them back on `ctrl_q`. The bits are: bit2 receive enable, bit3 receive disable, bit4 transmit enable, bit5 transmit disable, bit6 restart timeout, bit7 start break, bit8 stop break. Bits 0 and 1 always read back as zero.
- R3: Writing bit0 gives a one-cycle `rx_flush` pulse, and writing bit1 gives a one-cycle `tx_flush` pulse. The pulse appears in the cycle after the write edge and is low in the following cycle.
- R4: A control write with bits 0 and 1 both set raises `rx_flush` and `tx_flush` in the same cycle.
- R5: A path is on only when its enable bit is 1 and its disable bit is 0. When the path is off, no byte is routed to it.
- R6: `break_req` is 1 exactly when bit7 is 1 and bit8 is 0.
- R7: A mode write stores `mode_wr_data` on `mode_q`. The encodings are 0 normal, 1 echo, 2 local loopback and 3 remote loopback.
- R8: A line byte is pushed into the receive queue when the mode is normal or echo and the receive path is on. It is not pushed in local or remote loopback.
- R9: A line byte is retransmitted on `tx_valid` and `tx_byte` when the mode is echo or remote loopback and the transmit path is on.
- R10: A host data write is transmitted in normal mode (transmit path on) and pushed into the receive queue in local loopback (receive path on). In echo and remote loopback it is dropped.
- R11: A routed byte appears one cycle after its input strobe. Routing uses the mode and control word held before that edge, even when a mode or control write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 9 | Control word write value |
| mode_wr_en | input | 1 | Channel mode write strobe |
| mode_wr_data | input | 2 | Channel mode write value |
| line_rx_valid | input | 1 | Byte received from the line |
| line_rx_byte | input | 8 | Received line byte |
| host_wr_valid | input | 1 | Host write to the data register |
| host_wr_byte | input | 8 | Host data byte |
| ctrl_q | output | 9 | Control word read-back |
| mode_q | output | 2 | Channel mode read-back |
| tx_valid | output | 1 | Byte to the transmitter |
| tx_byte | output | 8 | Transmitted byte |
| rxq_push | output | 1 | Push into the receive queue |
| rxq_byte | output | 8 | Byte pushed into the receive queue |
| rx_flush | output | 1 | One-cycle receive-side reset pulse |
| tx_flush | output | 1 | One-cycle transmit-side reset pulse |
| break_req | output | 1 | Break request toward the line |

## Verification
The assertions assume that the strobe and data inputs are stable across each rising edge and that they are driven low while reset is held. With that assumption, the previous cycle's `ctrl_q`, `mode_q` and write inputs fully explain any strobe seen in the current cycle.

The stimulus drives all inputs on falling edges and returns every strobe to zero after a single cycle. It holds every input low during reset.

The routing sweep covers:
- every combination of mode, the four enable and disable bits, and the choice of line source, host source or both;
- a write that lands in the same cycle as a byte, which shows that the old setting decides the routing.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
    localparam int CTRL_W     = 9;
    localparam int BYTE_W     = 8;
    localparam int MODE_W     = 2;
    localparam int B_RXFLUSH  = 0;
    localparam int B_TXFLUSH  = 1;
    localparam int B_RXON     = 2;
    localparam int B_RXOFF    = 3;
    localparam int B_TXON     = 4;
    localparam int B_TXOFF    = 5;
    localparam int B_TORST    = 6;
    localparam int B_BRKGO    = 7;
    localparam int B_BRKHALT  = 8;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
    localparam int N_FLUSH    = 2;

    typedef enum logic [MODE_W-1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;
endpackage

// File: rtl/uart_cr_regs.sv
module uart_cr_regs
    import uart_chan_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q,
    output logic         rx_flush,
    output logic         tx_flush,
    output logic         rx_active,
    output logic         tx_active,
    output logic         break_req
);
    localparam logic [W-1:0] SC_MASK = W'((1 << B_RXFLUSH) | (1 << B_TXFLUSH));
    localparam int FLUSH_POS [N_FLUSH] = '{B_RXFLUSH, B_TXFLUSH};

    logic [W-1:0]       word_q;
    logic [N_FLUSH-1:0] flush_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= CTRL_RESET;
        end else if (wr_en) begin
            word_q <= wr_data & ~SC_MASK;
        end
    end

    for (genvar g = 0; g < N_FLUSH; g++) begin : g_flush
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flush_q[g] <= 1'b0;
            end else begin
                flush_q[g] <= wr_en & wr_data[FLUSH_POS[g]];
            end
        end
    end

    assign ctrl_q    = word_q;
    assign rx_flush  = flush_q[0];
    assign tx_flush  = flush_q[1];
    assign rx_active = word_q[B_RXON] & ~word_q[B_RXOFF];
    assign tx_active = word_q[B_TXON] & ~word_q[B_TXOFF];
    assign break_req = word_q[B_BRKGO] & ~word_q[B_BRKHALT];
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_chan_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              line_valid,
    input  logic [DW-1:0]     line_byte,
    input  logic              host_valid,
    input  logic [DW-1:0]     host_byte,
    output logic [MODE_W-1:0] mode_q,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    output logic              push_valid,
    output logic [DW-1:0]     push_byte
);
    chan_mode_e state;
    logic          tx_v_d, push_v_d;
    logic [DW-1:0] tx_b_d, push_b_d;

    // state register: any mode write jumps straight to the written state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_NORMAL;
        end else if (mode_wr_en) begin
            state <= chan_mode_e'(mode_wr_data);
        end
    end

    // routing decided by the state held before this edge
    always_comb begin
        tx_v_d   = 1'b0;
        tx_b_d   = '0;
        push_v_d = 1'b0;
        push_b_d = '0;
        unique case (state)
            CH_NORMAL: begin
                tx_v_d   = host_valid & tx_active;
                tx_b_d   = host_byte;
                push_v_d = line_valid & rx_active;
                push_b_d = line_byte;
            end
            CH_ECHO: begin
                tx_v_d   = line_valid & tx_active;
                tx_b_d   = line_byte;
                push_v_d = line_valid & rx_active;
                push_b_d = line_byte;
            end
            CH_LOCAL: begin
                push_v_d = host_valid & rx_active;
                push_b_d = host_byte;
            end
            CH_REMOTE: begin
                tx_v_d   = line_valid & tx_active;
                tx_b_d   = line_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
            push_valid <= 1'b0;
            push_byte  <= '0;
        end else begin
            tx_valid   <= tx_v_d;
            push_valid <= push_v_d;
            if (tx_v_d)   tx_byte   <= tx_b_d;
            if (push_v_d) push_byte <= push_b_d;
        end
    end

    assign mode_q = state;
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_chan_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int CW = CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [CW-1:0]     ctrl_wr_data,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    input  logic              line_rx_valid,
    input  logic [DW-1:0]     line_rx_byte,
    input  logic              host_wr_valid,
    input  logic [DW-1:0]     host_wr_byte,
    output logic [CW-1:0]     ctrl_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    output logic              rxq_push,
    output logic [DW-1:0]     rxq_byte,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              break_req
);
    logic rx_on, tx_on;

    uart_cr_regs #(.W(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr_en),
        .wr_data   (ctrl_wr_data),
        .ctrl_q    (ctrl_q),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .rx_active (rx_on),
        .tx_active (tx_on),
        .break_req (break_req)
    );

    uart_chan_router #(.DW(DW)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .rx_active    (rx_on),
        .tx_active    (tx_on),
        .line_valid   (line_rx_valid),
        .line_byte    (line_rx_byte),
        .host_valid   (host_wr_valid),
        .host_byte    (host_wr_byte),
        .mode_q       (mode_q),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .push_valid   (rxq_push),
        .push_byte    (rxq_byte)
    );
endmodule

// File: rtl/uart_chan_ctrl_chk.sv
module uart_chan_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr_en,
    input logic [8:0] ctrl_wr_data,
    input logic [8:0] ctrl_q,
    input logic [1:0] mode_q,
    input logic       tx_valid,
    input logic       rxq_push,
    input logic       rx_flush,
    input logic       tx_flush
);
    // R3
    rx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(ctrl_wr_en && ctrl_wr_data[0]));
    // R3
    tx_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(ctrl_wr_en && ctrl_wr_data[1]));
    // R4
    both_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr_en && ctrl_wr_data[1:0] == 2'b11) |-> (rx_flush && tx_flush));
    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(ctrl_q[4] && !ctrl_q[5]));
    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> $past(ctrl_q[2] && !ctrl_q[3]));
    // R10
    local_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(mode_q) != 2'd2));
    // R8
    remote_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> ($past(mode_q) != 2'd3));
endmodule

bind uart_chan_ctrl uart_chan_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_en   (ctrl_wr_en),
    .ctrl_wr_data (ctrl_wr_data),
    .ctrl_q       (ctrl_q),
    .mode_q       (mode_q),
    .tx_valid     (tx_valid),
    .rxq_push     (rxq_push),
    .rx_flush     (rx_flush),
    .tx_flush     (tx_flush)
);

// File: tb/tb_uart_chan_ctrl.sv
`timescale 1ns/1ps
module tb_uart_chan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr_en = 1'b0;
    logic [8:0] ctrl_wr_data = '0;
    logic       mode_wr_en = 1'b0;
    logic [1:0] mode_wr_data = '0;
    logic       line_rx_valid = 1'b0;
    logic [7:0] line_rx_byte = '0;
    logic       host_wr_valid = 1'b0;
    logic [7:0] host_wr_byte = '0;
    logic [8:0] ctrl_q;
    logic [1:0] mode_q;
    logic       tx_valid, rxq_push, rx_flush, tx_flush, break_req;
    logic [7:0] tx_byte, rxq_byte;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    uart_chan_ctrl dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [8:0] v);
        ctrl_wr_en = 1'b1; ctrl_wr_data = v;
        @(posedge clk); @(negedge clk);
        ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
    endtask

    task automatic wr_mode(logic [1:0] m);
        mode_wr_en = 1'b1; mode_wr_data = m;
        @(posedge clk); @(negedge clk);
        mode_wr_en = 1'b0; mode_wr_data = '0;
    endtask

    task automatic send(bit lv, logic [7:0] lb, bit hv, logic [7:0] hb);
        line_rx_valid = lv; line_rx_byte = lb;
        host_wr_valid = hv; host_wr_byte = hb;
        @(posedge clk); @(negedge clk);
        line_rx_valid = 1'b0; host_wr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 ctrl", ctrl_q, 9'h128);
        chk("R1 mode", mode_q, 0);
        chk("R1 strobes", {tx_valid, rxq_push, rx_flush, tx_flush, break_req}, 0);

        // R2 readback, self-clearing bits read zero
        wr_ctrl(9'h1D7);
        chk("R2 readback", ctrl_q, 9'h1D4);
        // R4 both pulses together
        chk("R4 flush pair", {rx_flush, tx_flush}, 2'b11);
        @(negedge clk);
        chk("R3 pulse ends", {rx_flush, tx_flush}, 2'b00);
        wr_ctrl(9'h001);
        chk("R3 rx only", {rx_flush, tx_flush}, 2'b10);
        chk("R2 reads zero", ctrl_q, 9'h000);
        wr_ctrl(9'h042);
        chk("R3 tx only", {rx_flush, tx_flush}, 2'b01);
        chk("R2 timeout bit", ctrl_q, 9'h040);
        @(negedge clk);
        chk("R3 tx ends", tx_flush, 0);

        // R6 break
        wr_ctrl(9'h080); chk("R6 start", break_req, 1);
        wr_ctrl(9'h180); chk("R6 both", break_req, 0);
        wr_ctrl(9'h100); chk("R6 stop", break_req, 0);
        wr_ctrl(9'h000); chk("R6 none", break_req, 0);

        // R5 R7 R8 R9 R10 sweep
        for (int m = 0; m < 4; m++) begin
            wr_mode(m[1:0]);
            chk("R7 mode", mode_q, m);
            for (int c = 0; c < 16; c++) begin
                bit rx_on, tx_on;
                rx_on = c[0] & ~c[1];
                tx_on = c[2] & ~c[3];
                wr_ctrl(9'(c << 2));
                for (int p = 1; p < 4; p++) begin
                    bit lv, hv, etx, epu;
                    logic [7:0] lb, hb, etb, epb;
                    lv = p[0]; hv = p[1];
                    lb = 8'(8'hA0 ^ (c * 4 + p));
                    hb = 8'(8'h35 + m * 64 + c * 3 + p);
                    etx = 0; epu = 0; etb = 0; epb = 0;
                    if (m == 0 && hv && tx_on) begin etx = 1; etb = hb; end
                    if ((m == 1 || m == 3) && lv && tx_on) begin etx = 1; etb = lb; end
                    if ((m == 0 || m == 1) && lv && rx_on) begin epu = 1; epb = lb; end
                    if (m == 2 && hv && rx_on) begin epu = 1; epb = hb; end
                    send(lv, lb, hv, hb);
                    // R5 R8 R9 R10
                    chk("R9/R10 tx_valid", tx_valid, etx);
                    chk("R8/R10 rxq_push", rxq_push, epu);
                    if (etx) chk("R9/R10 tx_byte", tx_byte, etb);
                    if (epu) chk("R8/R10 rxq_byte", rxq_byte, epb);
                end
            end
        end

        // R11 same-cycle mode write: old mode (normal) decides
        wr_mode(2'd0);
        wr_ctrl(9'h014);
        mode_wr_en = 1'b1; mode_wr_data = 2'd2;
        send(0, 8'h00, 1, 8'hC3);
        mode_wr_en = 1'b0;
        chk("R11 old mode tx", {tx_valid, tx_byte}, {1'b1, 8'hC3});
        chk("R11 old mode push", rxq_push, 0);
        chk("R11 new mode", mode_q, 2);
        // R11 same-cycle control write: old enables decide
        ctrl_wr_en = 1'b1; ctrl_wr_data = 9'h028;
        send(0, 8'h00, 1, 8'h7E);
        ctrl_wr_en = 1'b0;
        chk("R11 old ctrl push", {rxq_push, rxq_byte}, {1'b1, 8'h7E});
        send(0, 8'h00, 1, 8'h11);
        chk("R5 disabled push", rxq_push, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule